// File: doc/BRIEF.md
# Host Control Register Space with Channel Event Vector

This block is the host-visible control space of a DMA endpoint that serves up to twelve data channels. The host opens a downstream transfer on a channel by writing three registers: a length, an offset with a last-in-sequence flag, and a host buffer address. The block then tracks how many words of the transfer remain. Each host buffer holds a fixed number of words, 4 MB worth by default. Because the block looks ahead, it asks for the next buffer as soon as the remaining length shows that one will be needed. It also reports each buffer it has finished with. Releasing the final buffer marks the end of the transfer.

Events from every channel collect in one sticky event vector, and a single interrupt line stays high while any event is pending. There are three kinds of event: an upstream transfer started by a user core, a request for another buffer, and a buffer release. The host reads the vector in 32-bit segments, and each read clears the bits it returned. Details of an event, such as the length and offset of an upstream transfer or the remaining downstream length, are held in separate per-channel registers. The host reads them one at a time. On the host side the block offers a plain register write port and a register read port with one cycle of latency. On the channel side it offers per-channel strobes and buses.

Top module: `hcr_ctrl_space`

## Requirements
- R1: Host register addresses are {channel[7:4], register[3:0]}. Register 0 is the length in words, register 1 holds the offset in bits 30:0 and the last flag in bit 31, and register 2 is the buffer address. Once all three have been written on an idle channel, in any order, `dn_start` for that channel pulses for exactly the one cycle after the third write. `dn_len`, `dn_off`, `dn_last` and `dn_buf_addr` then carry the written values. Fewer than three writes give no pulse.
- R2: The next-buffer event (vector bit 3c+1) is raised at the start when the length exceeds BUF_WORDS. It is raised again at each buffer switch after which more than BUF_WORDS words remain.
- R3: The release event (vector bit 3c+2) is raised when the BUF_WORDS-th word of a buffer is consumed and when the final word of the transfer is consumed. The final word ends the transfer and drops `dn_buf_ok`. Register 5 reads the remaining word count.
- R4: A word is counted only on a `dn_beat` cycle with `dn_buf_ok` high. A buffer address written to register 2 during a transfer becomes `dn_buf_addr` at the next buffer boundary. If no such address was written, `dn_buf_ok` stays low from the boundary until one is written.
- R5: An `up_start` strobe sets the new-transfer event (vector bit 3c). It also stores the upstream length in register 3 and {last, offset} in register 4.
- R6: Channel field 4'hF with register k reads vector bits 32k+31..32k. The read clears those bits, but an event set in the same cycle as the read stays pending.
- R7: `host_irq` is high in every cycle in which a vector bit is pending, starting the cycle after the event. It goes low after the read that clears the vector and rises again on a later event.
- R8: Read data appears on `host_rdata` in the cycle after `host_rd` and holds until the next read. Registers 0 to 2 read back the staged values, and unmapped addresses read zero.
- R9: After reset, `host_irq`, `host_rdata`, `dn_start` and `dn_buf_ok` are zero and the vector is empty.
- R10: A start with length zero pulses `dn_start` and raises a release event at once. The channel never becomes active.
- R11: Writes to registers 0 and 1 during a transfer only stage the next transfer and leave the running transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_waddr | input | 8 | Write address {channel, register} |
| host_wdata | input | 32 | Write data |
| host_rd | input | 1 | Host register read strobe |
| host_raddr | input | 8 | Read address {channel, register} |
| host_rdata | output | 32 | Read data, one cycle after the strobe |
| host_irq | output | 1 | High while any event is pending |
| up_start | input | NCH | Per-channel upstream transfer start strobe |
| up_len | input | NCH*32 | Per-channel upstream length in words |
| up_off | input | NCH*31 | Per-channel upstream offset in words |
| up_last | input | NCH | Per-channel upstream last flag |
| dn_beat | input | NCH | Per-channel downstream word consumed |
| dn_start | output | NCH | Per-channel downstream start pulse |
| dn_len | output | NCH*32 | Length of the running downstream transfer |
| dn_off | output | NCH*31 | Offset of the running downstream transfer |
| dn_last | output | NCH | Last flag of the running downstream transfer |
| dn_buf_addr | output | NCH*32 | Host buffer address now in use |
| dn_buf_ok | output | NCH | A buffer is available for words on this channel |

## Verification
The start writes are applied in a scrambled order, as a partial set, with length zero, and with staging writes during a running transfer. These cases separate correct collection of the three writes from early or missed starts. One transfer with a small buffer size crosses two buffer boundaries. In one crossing the next address arrives early, and in the other it arrives late, with beats issued during the stall. This shows whether the look-ahead request, the address swap and the ignored beats behave correctly. Finally, a vector read is issued in the same cycle as a new event, which shows whether clear-on-read loses an event.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int REG_LEN   = 0;
  localparam int REG_OFF   = 1;
  localparam int REG_BUF   = 2;
  localparam int REG_ULEN  = 3;
  localparam int REG_UOFF  = 4;
  localparam int REG_REM   = 5;
  localparam int EV_NEW    = 0;
  localparam int EV_NEXT   = 1;
  localparam int EV_REL    = 2;
  localparam int EV_PER_CH = 3;
endpackage

// File: rtl/hcr_buf_track.sv
module hcr_buf_track #(
  parameter int LEN_W     = 32,
  parameter int AW        = 32,
  parameter int BUF_WORDS = 1 << 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic [AW-1:0]    start_addr,
  input  logic             addr_wr,
  input  logic [AW-1:0]    addr_data,
  input  logic             beat,
  output logic             busy,
  output logic             buf_ok,
  output logic [AW-1:0]    cur_addr,
  output logic [LEN_W-1:0] remaining,
  output logic             ev_next,
  output logic             ev_rel
);
  localparam int POS_W = $clog2(BUF_WORDS + 1);
  localparam logic [LEN_W-1:0] BUFW_L = LEN_W'(BUF_WORDS);
  localparam logic [POS_W-1:0] POS_END = POS_W'(BUF_WORDS - 1);

  logic             active_q, wait_q, have_q;
  logic [LEN_W-1:0] rem_q;
  logic [POS_W-1:0] pos_q;
  logic [AW-1:0]    cur_q, nxt_q;
  logic             take, last_word, full, more_after;

  assign take       = beat && active_q && !wait_q;
  assign last_word  = take && (rem_q == LEN_W'(1));
  assign full       = take && (pos_q == POS_END);
  assign more_after = (rem_q - LEN_W'(1)) > BUFW_L;

  // request the next buffer as soon as the remaining length needs one
  assign ev_next = (start && (start_len > BUFW_L)) ||
                   (full && !last_word && more_after);
  assign ev_rel  = (start && (start_len == '0)) || last_word || full;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      have_q   <= 1'b0;
      rem_q    <= '0;
      pos_q    <= '0;
      cur_q    <= '0;
      nxt_q    <= '0;
    end else if (start) begin
      active_q <= (start_len != '0);
      rem_q    <= start_len;
      pos_q    <= '0;
      cur_q    <= start_addr;
      have_q   <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      if (take) begin
        rem_q <= rem_q - LEN_W'(1);
        pos_q <= pos_q + POS_W'(1);
      end
      if (last_word) begin
        active_q <= 1'b0;
        have_q   <= 1'b0;
        wait_q   <= 1'b0;
        pos_q    <= '0;
      end else if (full) begin
        pos_q <= '0;
        if (have_q) begin
          cur_q  <= nxt_q;
          have_q <= 1'b0;
          if (addr_wr) begin
            nxt_q  <= addr_data;
            have_q <= 1'b1;
          end
        end else if (addr_wr) begin
          cur_q <= addr_data;
        end else begin
          wait_q <= 1'b1;
        end
      end else if (addr_wr && active_q) begin
        if (wait_q) begin
          cur_q  <= addr_data;
          wait_q <= 1'b0;
        end else begin
          nxt_q  <= addr_data;
          have_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = active_q;
  assign buf_ok    = active_q && !wait_q;
  assign cur_addr  = cur_q;
  assign remaining = rem_q;
endmodule

// File: rtl/hcr_chan.sv
module hcr_chan
  import hcr_pkg::*;
#(
  parameter int DW        = 32,
  parameter int BUF_WORDS = 1 << 20,
  parameter int REG_SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_hit,
  input  logic [REG_SEL_W-1:0] wr_reg,
  input  logic [DW-1:0]        wr_data,
  input  logic [REG_SEL_W-1:0] rd_reg,
  output logic [DW-1:0]        rd_val,
  input  logic                 up_start,
  input  logic [DW-1:0]        up_len,
  input  logic [DW-2:0]        up_off,
  input  logic                 up_last,
  input  logic                 beat,
  output logic                 dn_start,
  output logic [DW-1:0]        dn_len,
  output logic [DW-2:0]        dn_off,
  output logic                 dn_last,
  output logic [DW-1:0]        dn_buf_addr,
  output logic                 dn_buf_ok,
  output logic [EV_PER_CH-1:0] ev
);
  localparam int OFF_W = DW - 1;

  logic [2:0]       mask_q, mask_d, mask_bit;
  logic [DW-1:0]    len_q, len_d, addr_q, addr_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             last_q, last_d;
  logic [DW-1:0]    xlen_q;
  logic [OFF_W-1:0] xoff_q;
  logic             xlast_q, start_q;
  logic [DW-1:0]    ulen_q;
  logic [OFF_W-1:0] uoff_q;
  logic             ulast_q;
  logic             busy, stage_wr, next_addr_wr, start_now;
  logic             t_next, t_rel;
  logic [DW-1:0]    rem;

  assign next_addr_wr = wr_hit && (wr_reg == REG_SEL_W'(REG_BUF)) && busy;
  assign stage_wr     = wr_hit && (wr_reg <= REG_SEL_W'(REG_BUF)) && !next_addr_wr;

  always_comb begin
    mask_bit = 3'b000;
    len_d    = len_q;
    off_d    = off_q;
    last_d   = last_q;
    addr_d   = addr_q;
    if (stage_wr) begin
      case (wr_reg)
        REG_SEL_W'(REG_LEN): begin len_d = wr_data; mask_bit = 3'b001; end
        REG_SEL_W'(REG_OFF): begin
          off_d = wr_data[OFF_W-1:0]; last_d = wr_data[DW-1]; mask_bit = 3'b010;
        end
        default: begin addr_d = wr_data; mask_bit = 3'b100; end
      endcase
    end
    mask_d    = mask_q | mask_bit;
    start_now = (mask_d == 3'b111) && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      len_q   <= '0;
      off_q   <= '0;
      last_q  <= 1'b0;
      addr_q  <= '0;
      xlen_q  <= '0;
      xoff_q  <= '0;
      xlast_q <= 1'b0;
      start_q <= 1'b0;
      ulen_q  <= '0;
      uoff_q  <= '0;
      ulast_q <= 1'b0;
    end else begin
      mask_q  <= start_now ? 3'b000 : mask_d;
      len_q   <= len_d;
      off_q   <= off_d;
      last_q  <= last_d;
      addr_q  <= addr_d;
      start_q <= start_now;
      if (start_now) begin
        xlen_q  <= len_d;
        xoff_q  <= off_d;
        xlast_q <= last_d;
      end
      if (up_start) begin
        ulen_q  <= up_len;
        uoff_q  <= up_off;
        ulast_q <= up_last;
      end
    end
  end

  hcr_buf_track #(.LEN_W(DW), .AW(DW), .BUF_WORDS(BUF_WORDS)) u_trk (
    .clk(clk), .rst(rst), .start(start_now), .start_len(len_d), .start_addr(addr_d),
    .addr_wr(next_addr_wr), .addr_data(wr_data), .beat(beat),
    .busy(busy), .buf_ok(dn_buf_ok), .cur_addr(dn_buf_addr), .remaining(rem),
    .ev_next(t_next), .ev_rel(t_rel)
  );

  always_comb begin
    case (rd_reg)
      REG_SEL_W'(REG_LEN):  rd_val = len_q;
      REG_SEL_W'(REG_OFF):  rd_val = {last_q, off_q};
      REG_SEL_W'(REG_BUF):  rd_val = addr_q;
      REG_SEL_W'(REG_ULEN): rd_val = ulen_q;
      REG_SEL_W'(REG_UOFF): rd_val = {ulast_q, uoff_q};
      REG_SEL_W'(REG_REM):  rd_val = rem;
      default:              rd_val = '0;
    endcase
  end

  assign ev[EV_NEW]  = up_start;
  assign ev[EV_NEXT] = t_next;
  assign ev[EV_REL]  = t_rel;
  assign dn_start    = start_q;
  assign dn_len      = xlen_q;
  assign dn_off      = xoff_q;
  assign dn_last     = xlast_q;
endmodule

// File: rtl/hcr_evt_vec.sv
module hcr_evt_vec #(
  parameter int EVW       = 36,
  parameter int DW        = 32,
  parameter int SEG_SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EVW-1:0]       set,
  input  logic                 rd_clr,
  input  logic [SEG_SEL_W-1:0] rd_seg,
  output logic [EVW-1:0]       vec,
  output logic                 irq
);
  localparam int NSEG = (EVW + DW - 1) / DW;
  localparam int PADW = NSEG * DW;

  logic [PADW-1:0] clr_pad;
  logic [EVW-1:0]  vec_q, vec_d;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign clr_pad[s*DW +: DW] = {DW{rd_clr && (rd_seg == SEG_SEL_W'(s))}};
  end

  // a set in the same cycle as the clearing read survives
  assign vec_d = (vec_q & ~clr_pad[EVW-1:0]) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      irq   <= 1'b0;
    end else begin
      vec_q <= vec_d;
      irq   <= |vec_d;
    end
  end

  assign vec = vec_q;
endmodule

// File: rtl/hcr_ctrl_space.sv
module hcr_ctrl_space
  import hcr_pkg::*;
#(
  parameter int NCH       = 12,
  parameter int DW        = 32,
  parameter int BUF_WORDS = 1 << 20,
  parameter int CH_SEL_W  = 4,
  parameter int REG_SEL_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_wr,
  input  logic [CH_SEL_W+REG_SEL_W-1:0] host_waddr,
  input  logic [DW-1:0]                host_wdata,
  input  logic                         host_rd,
  input  logic [CH_SEL_W+REG_SEL_W-1:0] host_raddr,
  output logic [DW-1:0]                host_rdata,
  output logic                         host_irq,
  input  logic [NCH-1:0]               up_start,
  input  logic [NCH*DW-1:0]            up_len,
  input  logic [NCH*(DW-1)-1:0]        up_off,
  input  logic [NCH-1:0]               up_last,
  input  logic [NCH-1:0]               dn_beat,
  output logic [NCH-1:0]               dn_start,
  output logic [NCH*DW-1:0]            dn_len,
  output logic [NCH*(DW-1)-1:0]        dn_off,
  output logic [NCH-1:0]               dn_last,
  output logic [NCH*DW-1:0]            dn_buf_addr,
  output logic [NCH-1:0]               dn_buf_ok
);
  localparam int OFF_W = DW - 1;
  localparam int EVW   = EV_PER_CH * NCH;
  localparam int NSEG  = (EVW + DW - 1) / DW;
  localparam int PADW  = NSEG * DW;
  localparam logic [CH_SEL_W-1:0] PAGE_VEC = '1;

  logic [CH_SEL_W-1:0]  wch, rch;
  logic [REG_SEL_W-1:0] wreg, rreg;
  logic [EVW-1:0]       ev_set, vec;
  logic [PADW-1:0]      vec_pad;
  logic [DW-1:0]        rd_val_ch [NCH];
  logic [DW-1:0]        rd_val, rdata_q;
  logic                 vec_rd;

  assign wch  = host_waddr[CH_SEL_W+REG_SEL_W-1 -: CH_SEL_W];
  assign wreg = host_waddr[REG_SEL_W-1:0];
  assign rch  = host_raddr[CH_SEL_W+REG_SEL_W-1 -: CH_SEL_W];
  assign rreg = host_raddr[REG_SEL_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hcr_chan #(.DW(DW), .BUF_WORDS(BUF_WORDS), .REG_SEL_W(REG_SEL_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_hit(host_wr && (wch == CH_SEL_W'(c))), .wr_reg(wreg), .wr_data(host_wdata),
      .rd_reg(rreg), .rd_val(rd_val_ch[c]),
      .up_start(up_start[c]), .up_len(up_len[c*DW +: DW]),
      .up_off(up_off[c*OFF_W +: OFF_W]), .up_last(up_last[c]),
      .beat(dn_beat[c]),
      .dn_start(dn_start[c]), .dn_len(dn_len[c*DW +: DW]),
      .dn_off(dn_off[c*OFF_W +: OFF_W]), .dn_last(dn_last[c]),
      .dn_buf_addr(dn_buf_addr[c*DW +: DW]), .dn_buf_ok(dn_buf_ok[c]),
      .ev(ev_set[c*EV_PER_CH +: EV_PER_CH])
    );
  end

  assign vec_rd = host_rd && (rch == PAGE_VEC) && (rreg < REG_SEL_W'(NSEG));

  hcr_evt_vec #(.EVW(EVW), .DW(DW), .SEG_SEL_W(REG_SEL_W)) u_vec (
    .clk(clk), .rst(rst), .set(ev_set), .rd_clr(vec_rd), .rd_seg(rreg),
    .vec(vec), .irq(host_irq)
  );

  assign vec_pad = PADW'(vec);

  always_comb begin
    rd_val = '0;
    if (rch == PAGE_VEC) begin
      for (int s = 0; s < NSEG; s++)
        if (rreg == REG_SEL_W'(s)) rd_val = vec_pad[s*DW +: DW];
    end else begin
      for (int c = 0; c < NCH; c++)
        if (rch == CH_SEL_W'(c)) rd_val = rd_val_ch[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_val;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/hcr_ctrl_space_chk.sv
module hcr_ctrl_space_chk #(
  parameter int NCH = 12,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rd,
  input logic [DW-1:0]     host_rdata,
  input logic              host_irq,
  input logic [NCH-1:0]    up_start,
  input logic [NCH-1:0]    dn_start,
  input logic [NCH*DW-1:0] dn_len,
  input logic [NCH-1:0]    dn_buf_ok
);
  // R1
  one_start_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dn_start));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R1
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      dn_start[c] |=> !dn_start[c]);
    // R4
    start_ok_chk: assert property (@(posedge clk) disable iff (rst)
      (dn_start[c] && (dn_len[c*DW +: DW] != '0)) |-> dn_buf_ok[c]);
  end

  // R7
  irq_event_chk: assert property (@(posedge clk) disable iff (rst) (|up_start) |=> host_irq);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!host_irq && (dn_buf_ok == '0) && (dn_start == '0)));
endmodule

bind hcr_ctrl_space hcr_ctrl_space_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_rdata(host_rdata), .host_irq(host_irq),
  .up_start(up_start), .dn_start(dn_start), .dn_len(dn_len), .dn_buf_ok(dn_buf_ok)
);

// File: tb/sim_hcr_ctrl_space.sv
module sim_hcr_ctrl_space;
  localparam int CLK_P = 10;
  localparam int NCH   = 12;
  localparam int DW    = 32;
  localparam int OFW   = DW - 1;
  localparam int BW    = 4;
  localparam int EVW   = 3 * NCH;
  localparam int NSEG  = (EVW + DW - 1) / DW;

  logic clk = 0, rst = 1;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_waddr = 0, host_raddr = 0;
  logic [DW-1:0] host_wdata = 0, host_rdata;
  logic host_irq;
  logic [NCH-1:0] up_start = 0, up_last = 0, dn_beat = 0;
  logic [NCH*DW-1:0] up_len = 0;
  logic [NCH*OFW-1:0] up_off = 0;
  logic [NCH-1:0] dn_start, dn_last, dn_buf_ok;
  logic [NCH*DW-1:0] dn_len, dn_buf_addr;
  logic [NCH*OFW-1:0] dn_off;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  hcr_ctrl_space #(.NCH(NCH), .DW(DW), .BUF_WORDS(BW)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_raddr(host_raddr), .host_rdata(host_rdata), .host_irq(host_irq),
    .up_start(up_start), .up_len(up_len), .up_off(up_off), .up_last(up_last),
    .dn_beat(dn_beat), .dn_start(dn_start), .dn_len(dn_len), .dn_off(dn_off),
    .dn_last(dn_last), .dn_buf_addr(dn_buf_addr), .dn_buf_ok(dn_buf_ok)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [DW-1:0]  m_slen[NCH], m_saddr[NCH], m_xlen[NCH], m_ulen[NCH], m_cur[NCH], m_nxt[NCH];
  logic [OFW-1:0] m_soff[NCH], m_xoff[NCH], m_uoff[NCH];
  bit             m_slast[NCH], m_xlast[NCH], m_ulast[NCH];
  bit             m_act[NCH], m_wait[NCH], m_have[NCH], m_start[NCH];
  bit [2:0]       m_mask[NCH];
  int             m_rem[NCH], m_pos[NCH];
  logic [NSEG*DW-1:0] m_vec;
  logic [DW-1:0]  m_rdata;
  bit             m_irq;

  always @(posedge clk) begin : mdl
    logic [NSEG*DW-1:0] setv;
    logic [DW-1:0] rv;
    int wc, wr, rc, rr;
    bit wh, take, lastw, full, nadr, stage;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_slen[c] = 0; m_saddr[c] = 0; m_xlen[c] = 0; m_ulen[c] = 0; m_cur[c] = 0; m_nxt[c] = 0;
        m_soff[c] = 0; m_xoff[c] = 0; m_uoff[c] = 0; m_slast[c] = 0; m_xlast[c] = 0;
        m_ulast[c] = 0; m_act[c] = 0; m_wait[c] = 0; m_have[c] = 0; m_start[c] = 0;
        m_mask[c] = 0; m_rem[c] = 0; m_pos[c] = 0;
      end
      m_vec = 0; m_rdata = 0; m_irq = 0;
    end else begin
      wc = int'(host_waddr[7:4]); wr = int'(host_waddr[3:0]);
      rc = int'(host_raddr[7:4]); rr = int'(host_raddr[3:0]);
      rv = 0;
      if (rc == 15) begin
        if (rr < NSEG) rv = m_vec[rr*DW +: DW];
      end else if (rc < NCH) begin
        case (rr)
          0: rv = m_slen[rc];
          1: rv = {m_slast[rc], m_soff[rc]};
          2: rv = m_saddr[rc];
          3: rv = m_ulen[rc];
          4: rv = {m_ulast[rc], m_uoff[rc]};
          5: rv = DW'(m_rem[rc]);
          default: rv = 0;
        endcase
      end
      if (host_rd) m_rdata = rv;
      setv = 0;
      for (int c = 0; c < NCH; c++) begin
        wh    = host_wr && (wc == c);
        nadr  = wh && (wr == 2) && m_act[c];
        stage = wh && (wr <= 2) && !nadr;
        take  = dn_beat[c] && m_act[c] && !m_wait[c];
        lastw = take && (m_rem[c] == 1);
        full  = take && (m_pos[c] == BW - 1);
        m_start[c] = 0;
        if (stage) begin
          if (wr == 0) m_slen[c] = host_wdata;
          else if (wr == 1) begin m_soff[c] = host_wdata[OFW-1:0]; m_slast[c] = host_wdata[DW-1]; end
          else m_saddr[c] = host_wdata;
          m_mask[c][wr] = 1;
        end
        if (m_mask[c] == 3'b111 && !m_act[c]) begin
          m_mask[c] = 0; m_start[c] = 1;
          m_xlen[c] = m_slen[c]; m_xoff[c] = m_soff[c]; m_xlast[c] = m_slast[c];
          if (m_slen[c] == 0) setv[3*c+2] = 1;
          if (m_slen[c] > BW) setv[3*c+1] = 1;
          m_act[c] = (m_slen[c] != 0); m_rem[c] = int'(m_slen[c]); m_pos[c] = 0;
          m_cur[c] = m_saddr[c]; m_have[c] = 0; m_wait[c] = 0;
        end else begin
          if (take) begin
            if (full && !lastw && (m_rem[c] - 1 > BW)) setv[3*c+1] = 1;
            if (full || lastw) setv[3*c+2] = 1;
            m_rem[c]--; m_pos[c]++;
          end
          if (lastw) begin
            m_act[c] = 0; m_have[c] = 0; m_wait[c] = 0; m_pos[c] = 0;
          end else if (full) begin
            m_pos[c] = 0;
            if (m_have[c]) begin
              m_cur[c] = m_nxt[c]; m_have[c] = 0;
              if (nadr) begin m_nxt[c] = host_wdata; m_have[c] = 1; end
            end else if (nadr) m_cur[c] = host_wdata;
            else m_wait[c] = 1;
          end else if (nadr) begin
            if (m_wait[c]) begin m_cur[c] = host_wdata; m_wait[c] = 0; end
            else begin m_nxt[c] = host_wdata; m_have[c] = 1; end
          end
        end
        if (up_start[c]) begin
          m_ulen[c] = up_len[c*DW +: DW]; m_uoff[c] = up_off[c*OFW +: OFW];
          m_ulast[c] = up_last[c]; setv[3*c] = 1;
        end
      end
      if (host_rd && rc == 15 && rr < NSEG) m_vec[rr*DW +: DW] = 0;
      m_vec = m_vec | setv;
      m_irq = |m_vec;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 irq", host_irq, m_irq);
      chk("R8 rdata", host_rdata, m_rdata);
      for (int c = 0; c < NCH; c++) begin
        chk("R1 dn_start", dn_start[c], m_start[c]);
        chk("R1 dn_len", dn_len[c*DW +: DW], m_xlen[c]);
        chk("R1 dn_off", dn_off[c*OFW +: OFW], m_xoff[c]);
        chk("R1 dn_last", dn_last[c], m_xlast[c]);
        chk("R4 dn_buf_ok", dn_buf_ok[c], m_act[c] && !m_wait[c]);
        chk("R4 dn_buf_addr", dn_buf_addr[c*DW +: DW], m_cur[c]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic hwrite(input logic [7:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1 host_wr = 1; host_waddr = a; host_wdata = d;
    @(posedge clk); #1 host_wr = 0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [DW-1:0] d);
    @(posedge clk); #1 host_rd = 1; host_raddr = a;
    @(posedge clk); #1 host_rd = 0; d = host_rdata;
  endtask

  task automatic beats(input int c, input int n);
    @(posedge clk); #1 dn_beat[c] = 1;
    repeat (n) @(posedge clk);
    #1 dn_beat[c] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    idle(3);
    @(posedge clk); #1 rst = 0;
    idle(1);
    // R9 reset state
    chk("R9 irq", host_irq, 0);
    chk("R9 rdata", host_rdata, 0);
    chk("R9 buf_ok", dn_buf_ok, 0);

    // R1 scrambled order on channel 0
    hwrite(8'h02, 32'h1000);
    hwrite(8'h00, 32'd3);
    chk("R1 no start after two writes", dn_start[0], 0);
    hwrite(8'h01, 32'h8000_0005);
    chk("R1 start pulse", dn_start[0], 1);
    chk("R1 dn_len", dn_len[31:0], 3);
    chk("R1 dn_last", dn_last[0], 1);
    hread(8'h05, d); chk("R3 remaining", d, 3);
    hread(8'h02, d); chk("R8 staged readback", d, 32'h1000);
    beats(0, 3);
    chk("R3 ended", dn_buf_ok[0], 0);
    chk("R7 irq up", host_irq, 1);
    hread(8'hF0, d); chk("R3 release bit", d, 32'h4);
    idle(1);
    chk("R7 irq down", host_irq, 0);
    hread(8'hF0, d); chk("R6 cleared", d, 0);

    // R2 / R4 multi-buffer on channel 3
    hwrite(8'h30, 32'd10); hwrite(8'h31, 32'd0); hwrite(8'h32, 32'h3000);
    hread(8'hF0, d); chk("R2 next at start", d, 32'h400);
    hwrite(8'h32, 32'h3100);
    beats(3, 4);
    chk("R4 early next address", dn_buf_addr[3*DW +: DW], 32'h3100);
    hread(8'hF0, d); chk("R2 next and release", d, 32'hC00);
    beats(3, 4);
    chk("R4 stall without address", dn_buf_ok[3], 0);
    beats(3, 2);
    hread(8'h35, d); chk("R4 beats ignored", d, 2);
    hwrite(8'h32, 32'h3200);
    chk("R4 late address", dn_buf_addr[3*DW +: DW], 32'h3200);
    chk("R4 resume", dn_buf_ok[3], 1);
    beats(3, 2);
    chk("R3 end of transfer", dn_buf_ok[3], 0);
    hread(8'h35, d); chk("R3 remaining zero", d, 0);

    // R11 staging during a running transfer
    hwrite(8'h20, 32'd2); hwrite(8'h21, 32'd1); hwrite(8'h22, 32'h2000);
    hwrite(8'h20, 32'd7);
    chk("R11 running length kept", dn_len[2*DW +: DW], 2);
    hread(8'h20, d); chk("R11 staged length", d, 7);
    beats(2, 2);
    chk("R11 ended", dn_buf_ok[2], 0);

    // R5 upstream start on channel 11
    hread(8'hF0, d); hread(8'hF1, d);
    @(posedge clk); #1 up_start[11] = 1; up_len[11*DW +: DW] = 9; up_off[11*OFW +: OFW] = 4; up_last[11] = 1;
    @(posedge clk); #1 up_start[11] = 0;
    chk("R7 irq on upstream", host_irq, 1);
    hread(8'hF1, d); chk("R5 new bit", d, 32'h2);
    hread(8'hB3, d); chk("R5 upstream length", d, 9);
    hread(8'hB4, d); chk("R5 upstream offset", d, 32'h8000_0004);

    // R6 event in the same cycle as the clearing read
    hread(8'hF0, d);
    @(posedge clk); #1 host_rd = 1; host_raddr = 8'hF0; up_start[1] = 1; up_len[DW +: DW] = 5;
    @(posedge clk); #1 host_rd = 0; up_start[1] = 0;
    chk("R6 read before event", host_rdata, 0);
    hread(8'hF0, d); chk("R6 event kept", d, 32'h8);

    // R10 zero length start
    hwrite(8'h50, 32'd0); hwrite(8'h51, 32'd0); hwrite(8'h52, 32'h5000);
    chk("R10 start pulse", dn_start[5], 1);
    chk("R10 not active", dn_buf_ok[5], 0);
    hread(8'hF0, d); chk("R10 release bit", d, 32'h2_0000);

    // R1 partial set, R8 unmapped
    hwrite(8'h70, 32'd4); hwrite(8'h71, 32'd0);
    idle(3);
    chk("R1 partial no start", dn_start[7], 0);
    hread(8'h0A, d); chk("R8 unmapped register", d, 0);
    hread(8'hC0, d); chk("R8 unmapped channel", d, 0);
    hread(8'hF5, d); chk("R8 unmapped segment", d, 0);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule